// File: doc/BRIEF.md
# Slot-Specific I/O Slave Decoder

This block sits behind the slave side of a 32-bit PC expansion-bus card in a single slot. It watches each host I/O cycle and decides whether the card owns it. The system board already qualifies the slot by driving a per-slot address-enable low, so the block only has to look at the low twelve address bits. It accepts only the lowest quarter of each 1 KB block, which leaves four 256-byte windows.

A claimed cycle selects one of three targets:

- the network controller's register window in the first block;
- a 32-byte identification PROM in the last block, for which the block generates the PROM address;
- a small configuration register file in the last block, which lives inside this block.

The PROM holds two separate windows: a 4-byte product ID and an 8-byte node address. The block folds both into the one device by generating the PROM's top address bit.

For every claimed cycle the block also drives two bus responses. It asserts the 16-bit acknowledge for the controller and configuration targets. It drives the ready line, inserting wait states only while the network controller is busy. A timeout caps that wait so the bus cannot hang.

A cycle is taken on the rising clock edge at which START is sampled low. The address, M-IO, W/R, the byte enables and the write data must be valid at that edge. The target's outputs then appear in the next cycle.

Top module: `slot_io_decoder`

## Requirements
- R1: A cycle is claimed only when `aen` is 0, `m_io` is 0 (I/O space) and address bits 9 and 8 are both 0. Address bits 15:12 have no effect on the decode.
- R2: In the block with address bits 11:10 = 00, offsets 0x00–0x5F select the controller. `ctl_sel` is high, `ctl_reg` equals offset bits 6:1 and `ctl_wr` equals W/R.
- R3: Offsets 0x60–0xFF of block 00 are not claimed. Neither are blocks 01 and 10.
- R4: In block 11, reads at offsets 0x80–0x83 and 0x90–0x97 select the PROM, with `prom_addr` = {~offset[4], offset[3:0]}. Writes to these offsets are not claimed. Offsets 0x85–0x87, 0x8C–0x8E and 0x98–0xFF are not claimed.
- R5: In block 11, offsets 0x84, 0x88–0x8B and 0x8F select the configuration file for reads and writes. The layout is:

  | Offset | Bits | Field |
  |--------|------|-------|
  | 0x84 | bit0 | board enable |
  | 0x84 | bit1 | burst enable |
  | 0x88 | bit0 | level-triggered interrupt (0 = edge) |
  | 0x88 | bits 2:1 | interrupt line: 00 = IRQ5, 01 = IRQ9, 10 = IRQ10, 11 = IRQ11 |
  | 0x89 | bit0 | long preempt time (1 = 55 clocks, 0 = 23) |
  | 0x8A | bit0 | reject own packets |
  | 0x8A | bit1 | thick media |

  All other bits read 0. `rdata` carries the register during a read access and is 0 otherwise.
- R6: `ex16_n` is low exactly during controller and configuration accesses. It is high for PROM accesses and when idle.
- R7: A PROM or configuration access holds its select for exactly one cycle, with `io_rdy` high.
- R8: A controller access keeps `io_rdy` low until `ctl_rdy` is high, and it ends on that cycle. If `ctl_rdy` stays low for TMO_CYC (64) cycles, `io_rdy` is forced high in the next cycle.
- R9: After reset, board enable and burst enable are 1 and every other configuration field is 0.
- R10: A configuration write takes effect only when the byte enable of the lane addressed by address bits 1:0 is low. Writes to 0x8B and 0x8F change nothing, and both read 0.
- R11: Selects appear in the cycle after the edge that samples `start_n` low. A START that arrives while a controller access is waiting is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| aen | input | 1 | Slot address enable, low for this slot |
| m_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| start_n | input | 1 | Cycle start, active low |
| wr | input | 1 | 1 = write, 0 = read |
| be_n | input | 4 | Byte enables, active low |
| wdata | input | 8 | Write data for the configuration file |
| ctl_rdy | input | 1 | Controller has finished its access |
| ctl_sel | output | 1 | Controller register select |
| ctl_reg | output | 6 | Controller register index |
| ctl_wr | output | 1 | Controller access direction |
| prom_sel | output | 1 | ID PROM select |
| prom_addr | output | 5 | ID PROM byte address |
| cfg_sel | output | 1 | Configuration file select |
| rdata | output | 8 | Configuration read data |
| ex16_n | output | 1 | 16-bit transfer acknowledge, active low |
| io_rdy | output | 1 | Ready; low inserts wait states |
| cfg_board_en | output | 1 | Board enable field |
| cfg_burst_en | output | 1 | Burst enable field |
| cfg_irq_level | output | 1 | Level-triggered interrupt field |
| cfg_irq_sel | output | 2 | Interrupt line code |
| cfg_preempt_long | output | 1 | Long preempt time field |
| cfg_reject_own | output | 1 | Reject own packets field |
| cfg_thick | output | 1 | Thick media field |

## Verification
Selects, `prom_addr`, `ctl_reg`, `ex16_n` and `rdata` are due one cycle after the edge that takes START. The bench drives START at a falling edge and samples on the following falling edge, just after the taking edge. Written configuration fields become visible in that same cycle. `io_rdy` is combinational from `ctl_rdy` during a controller wait, so the bench changes `ctl_rdy` at a falling edge and reads `io_rdy` a moment later, counting 64 waiting cycles before the timeout. Every access is followed by one cycle that checks all selects have dropped and the configuration fields match the bench's model.

// File: rtl/slot_io_pkg.sv
package slot_io_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CTL  = 2'd1,
    TGT_PROM = 2'd2,
    TGT_CFG  = 2'd3
  } tgt_e;

  // 256-byte block numbers (address bits 11:10)
  localparam logic [1:0] BLK_CTL = 2'b00;
  localparam logic [1:0] BLK_ID  = 2'b11;

  // First offset past the controller register window
  localparam logic [7:0] CTL_LIMIT = 8'h60;

  // Configuration register offsets inside block 11
  localparam logic [7:0] OFF_CTRL  = 8'h84;
  localparam logic [7:0] OFF_IRQ   = 8'h88;
  localparam logic [7:0] OFF_PRE   = 8'h89;
  localparam logic [7:0] OFF_MEDIA = 8'h8A;
  localparam logic [7:0] OFF_SPA   = 8'h8B;
  localparam logic [7:0] OFF_SPB   = 8'h8F;

  function automatic logic is_cfg_off(input logic [7:0] off);
    return (off == OFF_CTRL) || (off == OFF_IRQ) || (off == OFF_PRE) ||
           (off == OFF_MEDIA) || (off == OFF_SPA) || (off == OFF_SPB);
  endfunction

  function automatic logic is_prom_off(input logic [7:0] off);
    return (off[7:2] == 6'b1000_00) || (off[7:3] == 5'b1001_0);
  endfunction

endpackage

// File: rtl/slot_io_addr_decode.sv
module slot_io_addr_decode
  import slot_io_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              aen,
  input  logic              m_io,
  input  logic              wr,
  output tgt_e              tgt
);

  logic       space_ok;
  logic [1:0] blk;
  logic [7:0] off;

  assign blk = addr[11:10];
  assign off = addr[7:0];

  // Claim only I/O cycles to this slot, in the low quarter of a 1 KB block
  assign space_ok = !aen && !m_io && (addr[9:8] == 2'b00);

  always_comb begin
    tgt = TGT_NONE;
    if (space_ok) begin
      case (blk)
        BLK_CTL: if (off < CTL_LIMIT) tgt = TGT_CTL;
        BLK_ID: begin
          if (!wr && is_prom_off(off)) tgt = TGT_PROM;
          else if (is_cfg_off(off))    tgt = TGT_CFG;
        end
        default: tgt = TGT_NONE;
      endcase
    end
  end

endmodule

// File: rtl/slot_io_cycle_ctrl.sv
module slot_io_cycle_ctrl
  import slot_io_pkg::*;
#(
  parameter int TMO_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_n,
  input  tgt_e       dec_tgt,
  input  logic [7:0] dec_off,
  input  logic       dec_wr,
  input  logic       ctl_rdy,
  output logic       accept,
  output tgt_e       cur_tgt,
  output logic [7:0] cur_off,
  output logic       cur_wr,
  output logic       io_rdy
);

  localparam int CW = $clog2(TMO_CYC + 1);

  tgt_e          tgt_q, tgt_d;
  logic [7:0]    off_q;
  logic          wr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tmo, wait_done, can_take;

  assign tmo       = (tgt_q == TGT_CTL) && (cnt_q == CW'(TMO_CYC));
  assign wait_done = (tgt_q != TGT_CTL) || ctl_rdy || tmo;
  assign can_take  = wait_done;
  assign accept    = can_take && !start_n && (dec_tgt != TGT_NONE);
  assign io_rdy    = wait_done;

  always_comb begin
    tgt_d = tgt_q;
    cnt_d = cnt_q;
    if (can_take) begin
      tgt_d = accept ? dec_tgt : TGT_NONE;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= TGT_NONE;
      cnt_q <= '0;
    end else begin
      tgt_q <= tgt_d;
      cnt_q <= cnt_d;
    end
  end

  // Access attributes load only when a cycle is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      wr_q  <= 1'b0;
    end else if (accept) begin
      off_q <= dec_off;
      wr_q  <= dec_wr;
    end
  end

  assign cur_tgt = tgt_q;
  assign cur_off = off_q;
  assign cur_wr  = wr_q;

  p_tmo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TMO_CYC));

  p_hold_while_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_q == TGT_CTL && !io_rdy) |=> (tgt_q == TGT_CTL) && $stable(off_q) && $stable(wr_q));

endmodule

// File: rtl/slot_io_cfg_regs.sv
module slot_io_cfg_regs
  import slot_io_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_off,
  input  logic [7:0] wdata,
  input  logic [7:0] rd_off,
  output logic [7:0] rd_data,
  output logic       board_en,
  output logic       burst_en,
  output logic       irq_level,
  output logic [1:0] irq_sel,
  output logic       preempt_long,
  output logic       reject_own,
  output logic       thick
);

  logic [1:0] ctrl_q;
  logic [2:0] irq_q;
  logic       pre_q;
  logic [1:0] media_q;
  logic       we_ctrl, we_irq, we_pre, we_media;

  assign we_ctrl  = wr_en && (wr_off == OFF_CTRL);
  assign we_irq   = wr_en && (wr_off == OFF_IRQ);
  assign we_pre   = wr_en && (wr_off == OFF_PRE);
  assign we_media = wr_en && (wr_off == OFF_MEDIA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= 2'b11;
    else if (we_ctrl) ctrl_q <= wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= '0;
    else if (we_irq) irq_q <= wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= 1'b0;
    else if (we_pre) pre_q <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        media_q <= '0;
    else if (we_media) media_q <= wdata[1:0];
  end

  always_comb begin
    case (rd_off)
      OFF_CTRL:  rd_data = {6'b0, ctrl_q};
      OFF_IRQ:   rd_data = {5'b0, irq_q};
      OFF_PRE:   rd_data = {7'b0, pre_q};
      OFF_MEDIA: rd_data = {6'b0, media_q};
      default:   rd_data = 8'h00;
    endcase
  end

  assign board_en     = ctrl_q[0];
  assign burst_en     = ctrl_q[1];
  assign irq_level    = irq_q[0];
  assign irq_sel      = irq_q[2:1];
  assign preempt_long = pre_q;
  assign reject_own   = media_q[0];
  assign thick        = media_q[1];

  p_irq_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_IRQ) |=> (irq_sel == $past(wdata[2:1])) && (irq_level == $past(wdata[0])));

  p_spare_noeffect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_off == OFF_SPA || wr_off == OFF_SPB)) |=>
      $stable(board_en) && $stable(burst_en) && $stable(irq_sel) && $stable(thick));

endmodule

// File: rtl/slot_io_decoder.sv
module slot_io_decoder
  import slot_io_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int TMO_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              aen,
  input  logic              m_io,
  input  logic              start_n,
  input  logic              wr,
  input  logic [3:0]        be_n,
  input  logic [7:0]        wdata,
  input  logic              ctl_rdy,
  output logic              ctl_sel,
  output logic [5:0]        ctl_reg,
  output logic              ctl_wr,
  output logic              prom_sel,
  output logic [4:0]        prom_addr,
  output logic              cfg_sel,
  output logic [7:0]        rdata,
  output logic              ex16_n,
  output logic              io_rdy,
  output logic              cfg_board_en,
  output logic              cfg_burst_en,
  output logic              cfg_irq_level,
  output logic [1:0]        cfg_irq_sel,
  output logic              cfg_preempt_long,
  output logic              cfg_reject_own,
  output logic              cfg_thick
);

  tgt_e       dec_tgt, cur_tgt;
  logic [7:0] cur_off;
  logic       cur_wr, accept, lane_on, cfg_we;
  logic [7:0] cfg_rd;
  logic       unused_slot_bits;

  assign unused_slot_bits = ^io_addr[ADDR_W-1:12];

  slot_io_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (io_addr),
    .aen  (aen),
    .m_io (m_io),
    .wr   (wr),
    .tgt  (dec_tgt)
  );

  slot_io_cycle_ctrl #(.TMO_CYC(TMO_CYC)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_n (start_n),
    .dec_tgt (dec_tgt),
    .dec_off (io_addr[7:0]),
    .dec_wr  (wr),
    .ctl_rdy (ctl_rdy),
    .accept  (accept),
    .cur_tgt (cur_tgt),
    .cur_off (cur_off),
    .cur_wr  (cur_wr),
    .io_rdy  (io_rdy)
  );

  assign lane_on = !be_n[io_addr[1:0]];
  assign cfg_we  = accept && (dec_tgt == TGT_CFG) && wr && lane_on;

  slot_io_cfg_regs u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_we),
    .wr_off       (io_addr[7:0]),
    .wdata        (wdata),
    .rd_off       (cur_off),
    .rd_data      (cfg_rd),
    .board_en     (cfg_board_en),
    .burst_en     (cfg_burst_en),
    .irq_level    (cfg_irq_level),
    .irq_sel      (cfg_irq_sel),
    .preempt_long (cfg_preempt_long),
    .reject_own   (cfg_reject_own),
    .thick        (cfg_thick)
  );

  assign ctl_sel   = (cur_tgt == TGT_CTL);
  assign prom_sel  = (cur_tgt == TGT_PROM);
  assign cfg_sel   = (cur_tgt == TGT_CFG);
  assign ctl_reg   = cur_off[6:1];
  assign ctl_wr    = cur_wr;
  assign prom_addr = {~cur_off[4], cur_off[3:0]};
  assign rdata     = (cfg_sel && !cur_wr) ? cfg_rd : 8'h00;
  assign ex16_n    = !(ctl_sel || cfg_sel);

  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_sel, prom_sel, cfg_sel}));

  p_prom_8bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prom_sel |-> ex16_n);

  p_no_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prom_sel || cfg_sel) |-> io_rdy);

  p_aen_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_n && (aen || m_io) && io_rdy) |=> !(ctl_sel || prom_sel || cfg_sel));

endmodule

// File: tb/slot_io_decoder_bench.sv
module slot_io_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        aen, m_io, start_n, wr, ctl_rdy;
  logic [3:0]  be_n;
  logic [7:0]  wdata;
  logic        ctl_sel, ctl_wr, prom_sel, cfg_sel, ex16_n, io_rdy;
  logic [5:0]  ctl_reg;
  logic [4:0]  prom_addr;
  logic [7:0]  rdata;
  logic        f_board, f_burst, f_lvl, f_pre, f_rej, f_thick;
  logic [1:0]  f_irq;

  always #5 clk = ~clk;

  slot_io_decoder u_slot_io_decoder (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .aen(aen), .m_io(m_io),
    .start_n(start_n), .wr(wr), .be_n(be_n), .wdata(wdata), .ctl_rdy(ctl_rdy),
    .ctl_sel(ctl_sel), .ctl_reg(ctl_reg), .ctl_wr(ctl_wr), .prom_sel(prom_sel),
    .prom_addr(prom_addr), .cfg_sel(cfg_sel), .rdata(rdata), .ex16_n(ex16_n),
    .io_rdy(io_rdy), .cfg_board_en(f_board), .cfg_burst_en(f_burst),
    .cfg_irq_level(f_lvl), .cfg_irq_sel(f_irq), .cfg_preempt_long(f_pre),
    .cfg_reject_own(f_rej), .cfg_thick(f_thick)
  );

  int n_vec = 0;
  int n_err = 0;
  bit finished = 0;

  // bench model of the configuration file
  logic       m_board, m_burst, m_lvl, m_pre, m_rej, m_thick;
  logic [1:0] m_irq;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h (t=%0t)", req, got, exp, $time);
    end
  endtask

  // 0 none, 1 controller, 2 PROM, 3 configuration
  function automatic int exp_tgt(input logic [15:0] a, input logic e, input logic mi, input logic w);
    logic [7:0] o;
    o = a[7:0];
    if (e || mi || a[9:8] != 2'b00) return 0;
    if (a[11:10] == 2'b00) return (o < 8'h60) ? 1 : 0;
    if (a[11:10] != 2'b11) return 0;
    if (!w && ((o >= 8'h80 && o <= 8'h83) || (o >= 8'h90 && o <= 8'h97))) return 2;
    if (o == 8'h84 || (o >= 8'h88 && o <= 8'h8B) || o == 8'h8F) return 3;
    return 0;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] o);
    case (o)
      8'h84:   return {6'b0, m_burst, m_board};
      8'h88:   return {5'b0, m_irq, m_lvl};
      8'h89:   return {7'b0, m_pre};
      8'h8A:   return {6'b0, m_thick, m_rej};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] o, input logic [7:0] d);
    case (o)
      8'h84: begin m_board = d[0]; m_burst = d[1]; end
      8'h88: begin m_lvl = d[0]; m_irq = d[2:1]; end
      8'h89: m_pre = d[0];
      8'h8A: begin m_rej = d[0]; m_thick = d[1]; end
      default: ;
    endcase
  endtask

  task automatic chk_fields(input string req);
    chk(req, {f_board, f_burst, f_lvl, f_irq, f_pre, f_rej, f_thick},
             {m_board, m_burst, m_lvl, m_irq, m_pre, m_rej, m_thick});
  endtask

  task automatic chk_idle(input string req);
    chk(req, {ctl_sel, prom_sel, cfg_sel, ex16_n, io_rdy}, 5'b00011);
  endtask

  // One host cycle. dly = controller wait cycles; tmo = never return ready;
  // poke = try a second START during the controller wait
  task automatic access(input logic [15:0] a, input logic e, input logic mi, input logic w,
                        input logic [3:0] be, input logic [7:0] d, input int dly,
                        input bit tmo, input bit poke);
    int t;
    int n;
    @(negedge clk);
    io_addr = a; aen = e; m_io = mi; wr = w; be_n = be; wdata = d;
    start_n = 1'b0; ctl_rdy = 1'b0;
    t = exp_tgt(a, e, mi, w);
    @(posedge clk);
    @(negedge clk);
    start_n = 1'b1;
    #1;
    case (t)
      0: begin
        chk("R1/R3 unclaimed", {ctl_sel, prom_sel, cfg_sel}, 3'b000);
        chk("R1 idle ready", io_rdy, 1'b1);
      end
      2: begin
        chk("R4 prom_sel", {ctl_sel, prom_sel, cfg_sel}, 3'b010);
        chk("R4 prom_addr", prom_addr, {~a[4], a[3:0]});
        chk("R6 prom ex16", ex16_n, 1'b1);
        chk("R7 prom ready", io_rdy, 1'b1);
      end
      3: begin
        if (w && !be[a[1:0]]) model_write(a[7:0], d);
        chk("R5 cfg_sel", {ctl_sel, prom_sel, cfg_sel}, 3'b001);
        chk("R6 cfg ex16", ex16_n, 1'b0);
        chk("R7 cfg ready", io_rdy, 1'b1);
        if (!w) chk("R5/R10 rdata", rdata, exp_rd(a[7:0]));
        chk_fields("R10 fields after write");
      end
      default: begin
        chk("R2 ctl_sel", {ctl_sel, prom_sel, cfg_sel}, 3'b100);
        chk("R2 ctl_reg", {ctl_reg, ctl_wr}, {a[6:1], w});
        chk("R6 ctl ex16", ex16_n, 1'b0);
        n = tmo ? 64 : dly;
        for (int k = 0; k < n; k++) begin
          chk("R8 wait", io_rdy, 1'b0);
          if (poke && k == 1) begin
            io_addr = 16'h0C84; wr = 1'b1; be_n = 4'h0; wdata = 8'h00; start_n = 1'b0;
          end
          @(posedge clk);
          @(negedge clk);
          start_n = 1'b1; io_addr = a; wr = w;
          #1;
          if (poke && k == 1) chk("R11 start ignored", {ctl_sel, ctl_reg}, {1'b1, a[6:1]});
        end
        if (!tmo) ctl_rdy = 1'b1;
        #1;
        chk(tmo ? "R8 timeout ready" : "R8 ready", io_rdy, 1'b1);
      end
    endcase
    @(posedge clk);
    @(negedge clk);
    ctl_rdy = 1'b0;
    #1;
    chk_idle("R7 access ended");
    chk_fields("R10 fields stable");
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_vec++; n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; io_addr = '0; aen = 1'b1; m_io = 1'b0; start_n = 1'b1;
    wr = 1'b0; be_n = 4'hF; wdata = '0; ctl_rdy = 1'b0;
    m_board = 1; m_burst = 1; m_lvl = 0; m_irq = 0; m_pre = 0; m_rej = 0; m_thick = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk_fields("R9 reset fields");
    chk_idle("R9 reset outputs");

    // R2 / R3 controller window edges
    access(16'h1000, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h105E, 0, 0, 1, 4'h0, 8'h00, 3, 0, 0);
    access(16'h1060, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h107F, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h10FF, 0, 0, 1, 4'h0, 8'h00, 0, 0, 0);
    // R1 qualification
    access(16'h2010, 1, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h2010, 0, 1, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h2110, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h2210, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h7010, 0, 0, 0, 4'h0, 8'h00, 1, 0, 0);
    access(16'h2480, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h2880, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    // R4 PROM windows
    access(16'h3C80, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h3C83, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h3C90, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h3C97, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h3C98, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h3C85, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h3C80, 0, 0, 1, 4'h0, 8'h00, 0, 0, 0);
    // R5 / R10 configuration file
    access(16'h3C88, 0, 0, 1, 4'hE, 8'h07, 0, 0, 0);
    access(16'h3C88, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h3C84, 0, 0, 1, 4'hF, 8'h00, 0, 0, 0);
    access(16'h3C84, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h3C84, 0, 0, 1, 4'hE, 8'h00, 0, 0, 0);
    access(16'h3C8A, 0, 0, 1, 4'hB, 8'h03, 0, 0, 0);
    access(16'h3C89, 0, 0, 1, 4'hD, 8'h01, 0, 0, 0);
    access(16'h3C8A, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h3C8B, 0, 0, 1, 4'h0, 8'hFF, 0, 0, 0);
    access(16'h3C8B, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h3C8F, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0);
    access(16'h3C84, 0, 0, 1, 4'h0, 8'h03, 0, 0, 0);
    // R8 timeout, R11 START during wait
    access(16'h1020, 0, 0, 0, 4'h0, 8'h00, 0, 1, 0);
    access(16'h1040, 0, 0, 1, 4'h0, 8'h00, 4, 0, 1);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic        e, mi, w;
      a = 16'($urandom);
      if ($urandom_range(3) != 0) a[9:8] = 2'b00;
      if ($urandom_range(1) == 0) begin a[11:10] = 2'b11; a[7:5] = 3'b100; end
      e  = ($urandom_range(7) == 0);
      mi = ($urandom_range(7) == 0);
      w  = 1'($urandom);
      access(a, e, mi, w, 4'($urandom), 8'($urandom), $urandom_range(4), 0, 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule